// File: doc/BRIEF.md
# SIMT Lane Mask Divergence Stack

This block keeps the set of enabled lanes for a group of threads that execute one instruction stream together. When a conditional branch splits the currently enabled lanes, the block saves the mask it had before the branch and the lanes that must wait for the other path. It then narrows the enabled set to the lanes whose condition is true. An else strobe switches execution to the waiting lanes. A reconvergence strobe acts as a barrier that brings back the saved pre-branch mask. Branches may nest up to a configured depth, and each nesting level uses one stack entry.

A branch whose condition is uniform across the enabled lanes still takes an entry, so that every branch is paired with exactly one reconvergence. Such an entry is marked non-divergent and the enabled set stays as it is. Errors are reported as one-cycle pulses and leave the state untouched. This covers a branch on a full stack, and an else or reconvergence on an empty stack. Fetch and program-counter sequencing live outside this block.

Top module: `simt_mask_stack`

## Requirements
- R1: After a synchronous active-low reset, every lane is enabled, the depth is 0, and both error flags are low.
- R2: A branch strobe whose condition has both true and false bits among the enabled lanes sets the enabled mask to (enabled AND condition) and raises the depth by one, effective on the next clock edge.
- R3: A branch strobe whose condition is the same for all enabled lanes (all true or all false among them) leaves the enabled mask unchanged and still raises the depth by one.
- R4: An else strobe on a non-empty stack sets the enabled mask to the lanes of the top entry's pre-branch mask whose condition was false at the branch. The depth is unchanged.
- R5: A reconvergence strobe on a non-empty stack restores the top entry's pre-branch mask and lowers the depth by one.
- R6: A branch strobe while the depth equals DEPTH raises overflow for exactly one cycle and changes neither the mask nor the depth.
- R7: An else or reconvergence strobe while the depth is 0 raises underflow for exactly one cycle and changes neither the mask nor the depth.
- R8: When several strobes arrive in one cycle, only one of them acts. Reconvergence beats else, and else beats branch.
- R9: Nested branches restore masks in last-in, first-out order, so leaving an inner branch brings back the mask of the enclosing path.
- R10: The error flags are low in every cycle that follows a strobe causing no error, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_lanes | input | LANES | Per-lane branch condition, sampled with the branch strobe |
| br_strobe | input | 1 | Conditional branch seen |
| else_strobe | input | 1 | Switch to the not-taken path of the innermost branch |
| reconv_strobe | input | 1 | Reconvergence point, pop the innermost branch |
| active_mask | output | LANES | Currently enabled lanes |
| depth | output | $clog2(DEPTH+1) | Number of stack entries in use |
| overflow | output | 1 | One-cycle pulse: branch on a full stack |
| underflow | output | 1 | One-cycle pulse: else or reconvergence on an empty stack |

## Verification
The bench fills the stack to exactly DEPTH entries and then strikes one more branch. A design with an off-by-one full test would either corrupt an entry or flag overflow one level early. It issues else and reconvergence on an empty stack, which a careless design would turn into a wrapped depth and a garbage mask. It also drives strobes together, because a wrong priority would pop and push in the same cycle. Random runs mix uniform all-true and all-false conditions with divergent ones, and an else after an inactive-lane-only split. These catch a design that narrows the mask on a uniform branch, or that forgets to AND the waiting lanes with the saved mask.

// File: rtl/simt_pkg.sv
// Package: shared operation encoding for the lane mask stack.
// Assumes: one operation is chosen per cycle by the controller.
package simt_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_SWAP  = 3'd2,
        OP_POP   = 3'd3,
        OP_OVF   = 3'd4,
        OP_UNF   = 3'd5
    } stk_op_e;
endpackage

// File: rtl/simt_split.sv
// Module: simt_split
// Splits the enabled lanes by a branch condition into taken and waiting
// sets and tells whether the branch diverges.
// Assumes: purely combinational, any lane count.
module simt_split #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] enabled,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] taken,
    output logic [LANES-1:0] waiting,
    output logic             diverges
);
    // Partition the enabled lanes and test that both sides are populated.
    always_comb begin
        taken    = enabled & cond;
        waiting  = enabled & ~cond;
        diverges = (|taken) && (|waiting);
    end
endmodule

// File: rtl/simt_ctrl.sv
// Module: simt_ctrl
// Chooses the single stack operation for this cycle from the strobes and
// the current depth; reconvergence outranks else, else outranks branch.
// Assumes: depth never exceeds DEPTH.
module simt_ctrl
    import simt_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          br,
    input  logic          el,
    input  logic          rc,
    input  logic [DW-1:0] depth,
    output stk_op_e       op
);
    localparam logic [DW-1:0] FULL = DW'(DEPTH);

    logic empty;
    logic full;

    // Stack occupancy tests.
    always_comb begin
        empty = (depth == '0);
        full  = (depth == FULL);
    end

    // Priority decode of the strobes into one operation.
    always_comb begin
        if (rc)      op = empty ? OP_UNF : OP_POP;
        else if (el) op = empty ? OP_UNF : OP_SWAP;
        else if (br) op = full  ? OP_OVF : OP_PUSH;
        else         op = OP_IDLE;
    end
endmodule

// File: rtl/simt_stack_mem.sv
// Module: simt_stack_mem
// Storage of DEPTH entries, each holding the pre-branch mask and the
// waiting-lane mask; written at wr_idx on push, read at rd_idx.
// Assumes: the caller only reads entries it has written.
module simt_stack_mem #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IW-1:0]    wr_idx,
    input  logic [LANES-1:0] saved_in,
    input  logic [LANES-1:0] wait_in,
    input  logic [IW-1:0]    rd_idx,
    output logic [LANES-1:0] top_saved,
    output logic [LANES-1:0] top_wait
);
    logic [LANES-1:0] saved_q [DEPTH];
    logic [LANES-1:0] wait_q  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Capture one entry when it is the push target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                saved_q[i] <= '0;
                wait_q[i]  <= '0;
            end else if (push && (wr_idx == IW'(i))) begin
                saved_q[i] <= saved_in;
                wait_q[i]  <= wait_in;
            end
        end
    end

    // Read port for the innermost entry.
    always_comb begin
        top_saved = saved_q[rd_idx];
        top_wait  = wait_q[rd_idx];
    end
endmodule

// File: rtl/simt_mask_stack.sv
// Module: simt_mask_stack
// Tracks the enabled lane mask across nested divergent branches using a
// mask stack; error flags are one-cycle pulses that leave state untouched.
// Assumes: synchronous active-low reset, DEPTH >= 2.
module simt_mask_stack
    import simt_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] cond_lanes,
    input  logic             br_strobe,
    input  logic             else_strobe,
    input  logic             reconv_strobe,
    output logic [LANES-1:0] active_mask,
    output logic [DW-1:0]    depth,
    output logic             overflow,
    output logic             underflow
);
    logic [LANES-1:0] mask_q;
    logic [DW-1:0]    depth_q;
    logic             ovf_q;
    logic             unf_q;

    logic [LANES-1:0] taken;
    logic [LANES-1:0] waiting;
    logic             diverges;
    logic [LANES-1:0] top_saved;
    logic [LANES-1:0] top_wait;
    logic [IW-1:0]    wr_idx;
    logic [IW-1:0]    rd_idx;
    stk_op_e          op;

    simt_split #(.LANES(LANES)) u_split (
        .enabled  (mask_q),
        .cond     (cond_lanes),
        .taken    (taken),
        .waiting  (waiting),
        .diverges (diverges)
    );

    simt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .br    (br_strobe),
        .el    (else_strobe),
        .rc    (reconv_strobe),
        .depth (depth_q),
        .op    (op)
    );

    // Stack pointers: next free slot and innermost used slot.
    always_comb begin
        wr_idx = depth_q[IW-1:0];
        rd_idx = IW'(depth_q - DW'(1));
    end

    simt_stack_mem #(.LANES(LANES), .DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (op == OP_PUSH),
        .wr_idx    (wr_idx),
        .saved_in  (mask_q),
        .wait_in   (waiting),
        .rd_idx    (rd_idx),
        .top_saved (top_saved),
        .top_wait  (top_wait)
    );

    // Apply the chosen operation to the mask, depth and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            depth_q <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            case (op)
                OP_PUSH: begin
                    depth_q <= depth_q + DW'(1);
                    if (diverges) mask_q <= taken;
                end
                OP_SWAP: mask_q <= top_wait & top_saved;
                OP_POP: begin
                    mask_q  <= top_saved;
                    depth_q <= depth_q - DW'(1);
                end
                OP_OVF:  ovf_q <= 1'b1;
                OP_UNF:  unf_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Drive the outputs from state.
    always_comb begin
        active_mask = mask_q;
        depth       = depth_q;
        overflow    = ovf_q;
        underflow   = unf_q;
    end

    // R6: an overflow pulse comes with no change of depth or mask.
    a_r6_overflow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (depth == DW'(DEPTH)) && $stable(depth) && $stable(active_mask));

    // R7: an underflow pulse only occurs on an empty stack that stayed empty.
    a_r7_underflow_empty: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (depth == '0) && $stable(active_mask));

    // R10: the two error pulses never coincide.
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));

    // R5: a reconvergence on a non-empty stack lowers the depth by one.
    a_r5_pop_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (reconv_strobe && depth != '0) |=> (depth == $past(depth) - DW'(1)));

    // R2: a branch never enables a lane that was idle before it.
    a_r2_branch_narrows: assert property (@(posedge clk) disable iff (!rst_n)
        (br_strobe && !else_strobe && !reconv_strobe) |=>
        ((active_mask & ~$past(active_mask)) == '0));

    // R8: a reconvergence strobe wins over a simultaneous branch strobe.
    a_r8_reconv_first: assert property (@(posedge clk) disable iff (!rst_n)
        (reconv_strobe && br_strobe && depth != '0) |=> !overflow && (depth < $past(depth)));
endmodule

// File: tb/simt_mask_stack_test.sv
module simt_mask_stack_test;
    localparam int LANES = 32;
    localparam int DEPTH = 8;
    localparam int DW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LANES-1:0] cond_lanes = '0;
    logic             br_strobe = 1'b0;
    logic             else_strobe = 1'b0;
    logic             reconv_strobe = 1'b0;
    logic [LANES-1:0] active_mask;
    logic [DW-1:0]    depth;
    logic             overflow;
    logic             underflow;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    logic [LANES-1:0] m_act;
    int               m_dep;
    logic             m_ovf;
    logic             m_unf;
    logic [LANES-1:0] m_saved [DEPTH];
    logic [LANES-1:0] m_wait  [DEPTH];

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cond_lanes    (cond_lanes),
        .br_strobe     (br_strobe),
        .else_strobe   (else_strobe),
        .reconv_strobe (reconv_strobe),
        .active_mask   (active_mask),
        .depth         (depth),
        .overflow      (overflow),
        .underflow     (underflow)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m_act = '1; m_dep = 0; m_ovf = 0; m_unf = 0;
    endtask

    // model one clock edge; returns the requirement tag of the action taken
    function automatic string model_step(input logic b, input logic e, input logic r,
                                         input logic [LANES-1:0] c);
        logic [LANES-1:0] tk, wt;
        string tag;
        m_ovf = 0; m_unf = 0;
        tk = m_act & c; wt = m_act & ~c;
        tag = "R10";
        if (r) begin
            if (m_dep == 0) begin m_unf = 1; tag = "R7"; end
            else begin m_dep--; m_act = m_saved[m_dep]; tag = (b || e) ? "R8" : "R5"; end
        end else if (e) begin
            if (m_dep == 0) begin m_unf = 1; tag = "R7"; end
            else begin m_act = m_wait[m_dep-1] & m_saved[m_dep-1]; tag = b ? "R8" : "R4"; end
        end else if (b) begin
            if (m_dep == DEPTH) begin m_ovf = 1; tag = "R6"; end
            else begin
                m_saved[m_dep] = m_act; m_wait[m_dep] = wt; m_dep++;
                if ((tk != 0) && (wt != 0)) begin m_act = tk; tag = "R2"; end
                else tag = "R3";
            end
        end
        return tag;
    endfunction

    // drive one cycle of strobes, then compare all outputs after the edge
    task automatic cyc(input logic b, input logic e, input logic r,
                       input logic [LANES-1:0] c, input string extra);
        string tag;
        @(negedge clk);
        br_strobe = b; else_strobe = e; reconv_strobe = r; cond_lanes = c;
        tag = model_step(b, e, r, c);
        if (extra != "") tag = extra;
        @(posedge clk); #1;
        check({tag, " mask"}, 64'(active_mask), 64'(m_act));
        check({tag, " depth"}, 64'(depth), 64'(m_dep));
        check({tag, " overflow"}, 64'(overflow), 64'(m_ovf));
        check({tag, " underflow"}, 64'(underflow), 64'(m_unf));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 mask", 64'(active_mask), 64'(32'hFFFF_FFFF));
        check("R1 depth", 64'(depth), 64'd0);
        check("R1 flags", 64'({overflow, underflow}), 64'd0);

        // R7 empty stack else / reconverge
        cyc(0, 0, 1, '0, "R7");
        cyc(0, 1, 0, '0, "R7");
        cyc(0, 0, 0, '0, "R10");

        // R9 nested: outer split, inner split, else inner, pop inner, else outer, pop
        cyc(1, 0, 0, 32'h0000_FFFF, "R2");
        cyc(1, 0, 0, 32'h0000_00FF, "R9");
        cyc(0, 1, 0, '0, "R4");
        cyc(0, 0, 1, '0, "R9");
        check("R9 inner restore", 64'(active_mask), 64'(32'h0000_FFFF));
        cyc(0, 1, 0, '0, "R4");
        check("R4 outer else", 64'(active_mask), 64'(32'hFFFF_0000));
        cyc(0, 0, 1, '0, "R5");
        check("R5 full restore", 64'(active_mask), 64'(32'hFFFF_FFFF));

        // R3 uniform branches
        cyc(1, 0, 0, 32'hFFFF_FFFF, "R3");
        cyc(1, 0, 0, 32'h0000_0000, "R3");
        cyc(0, 0, 1, '0, "R5");
        cyc(0, 0, 1, '0, "R5");

        // R6 fill to DEPTH then overflow
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, 32'h1 << i, "R6");
        cyc(1, 0, 0, 32'hAAAA_AAAA, "R6");
        cyc(0, 0, 0, '0, "R10");
        // R8 combined strobes at full depth
        cyc(1, 1, 1, 32'h5, "R8");
        cyc(1, 1, 0, 32'h5, "R8");
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, '0, "R9");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int sel;
            logic [LANES-1:0] c;
            sel = int'($urandom_range(0, 99));
            case ($urandom_range(0, 3))
                0: c = '1;
                1: c = '0;
                default: c = $urandom;
            endcase
            if (sel < 40)      cyc(1, 0, 0, c, "");
            else if (sel < 60) cyc(0, 1, 0, c, "");
            else if (sel < 88) cyc(0, 0, 1, c, "");
            else if (sel < 95) cyc(1'($urandom), 1'($urandom), 1'($urandom), c, "R8");
            else               cyc(0, 0, 0, c, "");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule